// File: doc/BRIEF.md
# Configuration Shadow Store Controller

This block keeps a nonvolatile copy of a device's eight configuration registers. When the controller leaves reset it copies the stored image into the live register file in one step. Until that copy is done, the register file stays at zero and host writes are refused. After that the host writes registers through a parallel port and reads the whole live image on a wide output. When software wants its settings to survive a power cycle, it pulses one of two save strobes. A plain save can be repeated any number of times. A locking save also sets a lock bit that is stored in the array, and after that bit is set no further save takes effect.

A save occupies the block for a fixed hold window, which stands for the long write time of the storage cells. During the window `busy` is high, host register writes are masked and save strobes are dropped. The window length is derived from the clock frequency and a millisecond count, so a small frequency shortens it for simulation. Two resets exist. `por_n` models the first power-on: it sets the array to its delivery image and clears the lock bit. `rst_n` is the ordinary device reset: it restarts the controller, and the next restore brings back both the image and the lock bit.

The controller has four states. LOAD is entered on reset and copies the array and its lock bit into the live registers. LOAD always moves to IDLE after one cycle. IDLE moves to SAVE when a save strobe arrives and the block is not locked. SAVE writes one register per cycle into the array. After the last register, SAVE moves to HOLD. HOLD waits until the window has fully elapsed, sets the lock bit if a locking save was requested, and returns to IDLE.

Top module: `nvshadow_ctrl`

## Requirements
- R1: While `rst_n` is low and in the first cycle after it rises, `restore_done` is 0 and `cfg_image` is all zeros. The first rising clock edge with `rst_n` high loads the stored image into `cfg_image` and sets `restore_done` to 1.
- R2: The image holds NUM_REGS=8 registers of REG_W=23 bits each, 184 bits in total. Register i occupies `cfg_image[23*i+22 : 23*i]`, and `host_addr` selects register i by the binary value i.
- R3: In IDLE and unlocked, a `cmd_save` pulse copies all live registers into the array. This can be repeated without limit, and each save is seen as the restored image after the next `rst_n` pulse.
- R4: A `cmd_save_lock` pulse saves in the same way and sets the stored lock bit when the hold window ends. From that edge `locked` reads 1. `locked` stays 1 across `rst_n` pulses because the restore reloads it, and only `por_n` clears it.
- R5: After a save is accepted, `busy` is high for exactly HOLD_CYCLES clock cycles, starting at the accepting edge. HOLD_CYCLES is CLK_HZ/1000*HOLD_MS, raised to NUM_REGS+1 if it is smaller.
- R6: While `busy` is high, save strobes are dropped without raising an error, and host register writes have no effect.
- R7: While locked, a save strobe in IDLE starts no save, leaves the array unchanged, and sets `err_locked`. `err_locked` stays 1 until `rst_n` goes low.
- R8: In IDLE, a host write with `host_we` high updates the addressed register at the next edge. A write in the restore cycle is overwritten by the restored image.
- R9: If both save strobes are high in the same cycle, the save is treated as a locking save.
- R10: A host write in the same cycle as an accepted save is dropped. A host write in the same cycle as a save rejected because of the lock is applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, active low; sets the array to its delivery image and clears the lock bit |
| rst_n | input | 1 | Device reset, active low; restarts the controller and triggers a restore |
| cmd_save | input | 1 | Strobe for a repeatable save |
| cmd_save_lock | input | 1 | Strobe for a save that also sets the lock |
| host_we | input | 1 | Host register write enable |
| host_addr | input | 3 | Register index for a host write |
| host_wdata | input | 23 | Data for a host write |
| cfg_image | output | 184 | Live contents of all registers |
| busy | output | 1 | High during the hold window of a save |
| restore_done | output | 1 | High once the restore after reset has completed |
| locked | output | 1 | Stored lock bit as seen by the controller |
| err_locked | output | 1 | Sticky flag: a save was attempted while locked |

## Verification
The bench builds the block with CLK_HZ=20000 and HOLD_MS=1, which gives a 20-cycle hold window. That window is short enough to count every cycle of `busy`, and long enough for the eight-cycle SAVE phase and the HOLD phase both to occur. A non-zero delivery image is supplied through NV_INIT, so each restore shows up at the ports. Saved contents, the lock bit and the rejection of saves while locked are all observed at the ports by pulsing `rst_n` or `por_n` and reading the restored image.

// File: rtl/nvs_pkg.sv
package nvs_pkg;

    typedef enum logic [1:0] {
        ST_LOAD = 2'd0,
        ST_IDLE = 2'd1,
        ST_SAVE = 2'd2,
        ST_HOLD = 2'd3
    } nvs_state_e;

    function automatic int unsigned hold_len(input int unsigned clk_hz,
                                             input int unsigned hold_ms,
                                             input int unsigned nregs);
        int unsigned raw;
        raw = (clk_hz / 1000) * hold_ms;
        return (raw > nregs) ? raw : nregs + 1;
    endfunction

endpackage

// File: rtl/nvs_nvarray.sv
module nvs_nvarray #(
    parameter int NUM_REGS = 8,
    parameter int REG_W    = 23,
    parameter int IDX_W    = 3,
    parameter logic [NUM_REGS*REG_W-1:0] INIT = '0
) (
    input  logic                      clk,
    input  logic                      por_n,
    input  logic                      wr_en,
    input  logic [IDX_W-1:0]          wr_idx,
    input  logic [REG_W-1:0]          wr_word,
    input  logic                      set_lock,
    output logic [NUM_REGS*REG_W-1:0] image,
    output logic                      lock_bit
);

    logic [NUM_REGS*REG_W-1:0] cells_q;
    logic                      lock_q;

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            cells_q <= INIT;
        end else if (wr_en) begin
            cells_q[wr_idx*REG_W +: REG_W] <= wr_word;
        end
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            lock_q <= 1'b0;
        end else if (set_lock) begin
            lock_q <= 1'b1;
        end
    end

    assign image    = cells_q;
    assign lock_bit = lock_q;

    // R4: once set, the lock bit is never cleared before the next power-on
    a_r4_lock_persists: assert property (@(posedge clk) disable iff (!por_n)
        lock_q |=> lock_q);

    // R7: a locked array accepts no writes
    a_r7_locked_no_write: assert property (@(posedge clk) disable iff (!por_n)
        lock_q |-> !wr_en);

endmodule

// File: rtl/nvs_regfile.sv
module nvs_regfile #(
    parameter int NUM_REGS = 8,
    parameter int REG_W    = 23,
    parameter int IDX_W    = 3
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      load_all,
    input  logic [NUM_REGS*REG_W-1:0] load_image,
    input  logic                      wr_en,
    input  logic [IDX_W-1:0]          wr_idx,
    input  logic [REG_W-1:0]          wr_word,
    output logic [NUM_REGS*REG_W-1:0] image
);

    for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
        logic [REG_W-1:0] word_q;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                word_q <= '0;
            end else if (load_all) begin
                word_q <= load_image[i*REG_W +: REG_W];
            end else if (wr_en && (wr_idx == IDX_W'(i))) begin
                word_q <= wr_word;
            end
        end

        assign image[i*REG_W +: REG_W] = word_q;
    end

endmodule

// File: rtl/nvs_fsm.sv
module nvs_fsm
    import nvs_pkg::*;
#(
    parameter int NUM_REGS    = 8,
    parameter int IDX_W       = 3,
    parameter int HOLD_CYCLES = 9,
    parameter int CNT_W       = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_save,
    input  logic             cmd_lock,
    input  logic             nv_lock,
    output logic             load_all,
    output logic             host_wr_ok,
    output logic             nv_wr_en,
    output logic [IDX_W-1:0] nv_wr_idx,
    output logic             set_lock,
    output logic             busy,
    output logic             restore_done,
    output logic             locked,
    output logic             err_locked
);

    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_REGS - 1);
    localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(HOLD_CYCLES - 1);

    nvs_state_e       state_q, state_d;
    logic [IDX_W-1:0] idx_q;
    logic [CNT_W-1:0] cnt_q;
    logic             pend_lock_q;
    logic             lock_q;
    logic             err_q;
    logic             any_cmd;
    logic             accept;
    logic             reject;
    logic             hold_end;

    assign any_cmd  = cmd_save | cmd_lock;
    assign accept   = (state_q == ST_IDLE) && any_cmd && !lock_q;
    assign reject   = (state_q == ST_IDLE) && any_cmd && lock_q;
    assign hold_end = (state_q == ST_HOLD) && (cnt_q == LAST_CNT);

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_LOAD: state_d = ST_IDLE;
            ST_IDLE: if (accept)            state_d = ST_SAVE;
            ST_SAVE: if (idx_q == LAST_IDX) state_d = ST_HOLD;
            ST_HOLD: if (hold_end)          state_d = ST_IDLE;
            default: state_d = ST_LOAD;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_LOAD;
        end else begin
            state_q <= state_d;
        end
    end

    // datapath registers steered by the state
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idx_q       <= '0;
            cnt_q       <= '0;
            pend_lock_q <= 1'b0;
            lock_q      <= 1'b0;
            err_q       <= 1'b0;
        end else begin
            idx_q <= (state_q == ST_SAVE) ? idx_q + 1'b1 : '0;
            if (accept) begin
                cnt_q       <= '0;
                pend_lock_q <= cmd_lock;
            end else if (busy) begin
                cnt_q <= cnt_q + 1'b1;
            end
            if (state_q == ST_LOAD) begin
                lock_q <= nv_lock;
            end else if (hold_end && pend_lock_q) begin
                lock_q <= 1'b1;
            end
            if (reject) begin
                err_q <= 1'b1;
            end
        end
    end

    // outputs decoded from the state
    always_comb begin
        load_all     = 1'b0;
        host_wr_ok   = 1'b0;
        nv_wr_en     = 1'b0;
        busy         = 1'b0;
        restore_done = 1'b1;
        unique case (state_q)
            ST_LOAD: begin
                load_all     = 1'b1;
                restore_done = 1'b0;
            end
            ST_IDLE: host_wr_ok = !accept;
            ST_SAVE: begin
                nv_wr_en = 1'b1;
                busy     = 1'b1;
            end
            ST_HOLD: busy = 1'b1;
            default: restore_done = 1'b0;
        endcase
    end

    assign nv_wr_idx  = idx_q;
    assign set_lock   = hold_end && pend_lock_q;
    assign locked     = lock_q;
    assign err_locked = err_q;

    // R5: the hold counter never runs past the window while busy
    a_r5_window_bound: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (cnt_q <= LAST_CNT));

    // R5: busy begins exactly on the edge that accepts a save
    a_r5_busy_on_accept: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> busy);

    // R7: the error flag is sticky until reset
    a_r7_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        err_q |=> err_q);

    // R4: the controller's view of the lock never falls while out of reset
    a_r4_view_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (lock_q && state_q != ST_LOAD) |=> lock_q);

    // R6: no write to the register file is allowed during a save
    a_r6_no_host_write_busy: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !host_wr_ok);

endmodule

// File: rtl/nvshadow_ctrl.sv
module nvshadow_ctrl
    import nvs_pkg::*;
#(
    parameter int NUM_REGS = 8,
    parameter int REG_W    = 23,
    parameter int CLK_HZ   = 100_000_000,
    parameter int HOLD_MS  = 50,
    parameter logic [NUM_REGS*REG_W-1:0] NV_INIT = '0
) (
    input  logic                                  clk,
    input  logic                                  por_n,
    input  logic                                  rst_n,
    input  logic                                  cmd_save,
    input  logic                                  cmd_save_lock,
    input  logic                                  host_we,
    input  logic [((NUM_REGS > 1) ? $clog2(NUM_REGS) : 1)-1:0] host_addr,
    input  logic [REG_W-1:0]                      host_wdata,
    output logic [NUM_REGS*REG_W-1:0]             cfg_image,
    output logic                                  busy,
    output logic                                  restore_done,
    output logic                                  locked,
    output logic                                  err_locked
);

    localparam int IDX_W       = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1;
    localparam int IMG_W       = NUM_REGS * REG_W;
    localparam int HOLD_CYCLES = int'(hold_len(CLK_HZ, HOLD_MS, NUM_REGS));
    localparam int CNT_W       = $clog2(HOLD_CYCLES + 1);

    logic             load_all;
    logic             host_wr_ok;
    logic             nv_wr_en;
    logic [IDX_W-1:0] nv_wr_idx;
    logic             set_lock;
    logic             nv_lock;
    logic [IMG_W-1:0] nv_image;
    logic [IMG_W-1:0] live_image;

    nvs_fsm #(
        .NUM_REGS   (NUM_REGS),
        .IDX_W      (IDX_W),
        .HOLD_CYCLES(HOLD_CYCLES),
        .CNT_W      (CNT_W)
    ) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .cmd_save    (cmd_save),
        .cmd_lock    (cmd_save_lock),
        .nv_lock     (nv_lock),
        .load_all    (load_all),
        .host_wr_ok  (host_wr_ok),
        .nv_wr_en    (nv_wr_en),
        .nv_wr_idx   (nv_wr_idx),
        .set_lock    (set_lock),
        .busy        (busy),
        .restore_done(restore_done),
        .locked      (locked),
        .err_locked  (err_locked)
    );

    nvs_regfile #(
        .NUM_REGS(NUM_REGS),
        .REG_W   (REG_W),
        .IDX_W   (IDX_W)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .load_all  (load_all),
        .load_image(nv_image),
        .wr_en     (host_we && host_wr_ok),
        .wr_idx    (host_addr),
        .wr_word   (host_wdata),
        .image     (live_image)
    );

    nvs_nvarray #(
        .NUM_REGS(NUM_REGS),
        .REG_W   (REG_W),
        .IDX_W   (IDX_W),
        .INIT    (NV_INIT)
    ) u_nv (
        .clk     (clk),
        .por_n   (por_n),
        .wr_en   (nv_wr_en),
        .wr_idx  (nv_wr_idx),
        .wr_word (live_image[nv_wr_idx*REG_W +: REG_W]),
        .set_lock(set_lock),
        .image   (nv_image),
        .lock_bit(nv_lock)
    );

    assign cfg_image = live_image;

    // R1: registers hold their reset value until the restore completes
    a_r1_held_until_restore: assert property (@(posedge clk) disable iff (!rst_n)
        !restore_done |-> (cfg_image == '0));

    // R6: the live image does not move during a save window
    a_r6_frozen_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> $stable(cfg_image));

    // R3: each register written to storage matches the live register
    a_r3_save_copies_live: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
        nv_wr_en |=> (nv_image[$past(nv_wr_idx)*REG_W +: REG_W]
                      == live_image[$past(nv_wr_idx)*REG_W +: REG_W]));

endmodule

// File: tb/nvshadow_ctrl_bench.sv
`timescale 1ns/1ps
module nvshadow_ctrl_bench;

    localparam int NR    = 8;
    localparam int RW    = 23;
    localparam int IMG_W = NR * RW;
    localparam int HOLD  = 20;

    function automatic logic [IMG_W-1:0] make_init();
        logic [IMG_W-1:0] v;
        for (int i = 0; i < NR; i++) begin
            v[i*RW +: RW] = RW'(23'h10001 + i * 23'h0B3C5);
        end
        return v;
    endfunction

    localparam logic [IMG_W-1:0] INIT_IMG = make_init();

    logic             clk = 1'b0;
    logic             por_n = 1'b0;
    logic             rst_n = 1'b0;
    logic             cmd_save = 1'b0;
    logic             cmd_save_lock = 1'b0;
    logic             host_we = 1'b0;
    logic [2:0]       host_addr = '0;
    logic [RW-1:0]    host_wdata = '0;
    logic [IMG_W-1:0] cfg_image;
    logic             busy, restore_done, locked, err_locked;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    nvshadow_ctrl #(
        .NUM_REGS(NR), .REG_W(RW), .CLK_HZ(20000), .HOLD_MS(1), .NV_INIT(INIT_IMG)
    ) u_nvshadow_ctrl (
        .clk(clk), .por_n(por_n), .rst_n(rst_n),
        .cmd_save(cmd_save), .cmd_save_lock(cmd_save_lock),
        .host_we(host_we), .host_addr(host_addr), .host_wdata(host_wdata),
        .cfg_image(cfg_image), .busy(busy), .restore_done(restore_done),
        .locked(locked), .err_locked(err_locked)
    );

    task automatic chk(input string tag, input logic [IMG_W-1:0] act, input logic [IMG_W-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [RW-1:0] word_of(input logic [IMG_W-1:0] img, input int i);
        return img[i*RW +: RW];
    endfunction

    // behavioural reference model
    logic [RW-1:0] m_reg [NR];
    logic [RW-1:0] m_nv  [NR];
    logic          m_nvlock, m_locked, m_err, m_pend;
    int            m_phase;   // 0 restoring, 1 idle, 2 saving
    int            m_cnt;
    bit            m_started = 0;

    function automatic logic [IMG_W-1:0] m_flat();
        logic [IMG_W-1:0] v;
        for (int i = 0; i < NR; i++) v[i*RW +: RW] = m_reg[i];
        return v;
    endfunction

    always @(posedge clk) begin
        if (!por_n) begin
            for (int i = 0; i < NR; i++) m_nv[i] = word_of(INIT_IMG, i);
            m_nvlock = 1'b0;
        end
        if (!rst_n) begin
            m_phase = 0; m_cnt = 0; m_pend = 0; m_locked = 0; m_err = 0;
            for (int i = 0; i < NR; i++) m_reg[i] = '0;
        end else begin
            case (m_phase)
                0: begin
                    for (int i = 0; i < NR; i++) m_reg[i] = m_nv[i];
                    m_locked = m_nvlock;
                    m_phase = 1;
                end
                1: begin
                    if (cmd_save || cmd_save_lock) begin
                        if (m_locked) begin
                            m_err = 1'b1;
                            if (host_we) m_reg[host_addr] = host_wdata;
                        end else begin
                            m_phase = 2; m_cnt = 0; m_pend = cmd_save_lock;
                            for (int i = 0; i < NR; i++) m_nv[i] = m_reg[i];
                        end
                    end else if (host_we) begin
                        m_reg[host_addr] = host_wdata;
                    end
                end
                default: begin
                    m_cnt++;
                    if (m_cnt == HOLD) begin
                        m_phase = 1;
                        if (m_pend) begin m_nvlock = 1'b1; m_locked = 1'b1; end
                    end
                end
            endcase
        end
        m_started = 1;
        #2;
        chk("R8 model image", cfg_image, m_flat());
        chk("R5 model busy", IMG_W'(busy), IMG_W'(m_phase == 2));
        chk("R1 model restore_done", IMG_W'(restore_done), IMG_W'(m_phase != 0));
        chk("R4 model locked", IMG_W'(locked), IMG_W'(m_locked));
        chk("R7 model err_locked", IMG_W'(err_locked), IMG_W'(m_err));
    end

    task automatic reset_pulse();
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic host_write(input int a, input logic [RW-1:0] d);
        @(negedge clk); host_we = 1'b1; host_addr = 3'(a); host_wdata = d;
        @(negedge clk); host_we = 1'b0;
    endtask

    task automatic save(input bit lk);
        @(negedge clk); cmd_save = !lk; cmd_save_lock = lk;
        @(negedge clk); cmd_save = 1'b0; cmd_save_lock = 1'b0;
    endtask

    task automatic wait_idle();
        while (busy) @(negedge clk);
    endtask

    task automatic summary();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL R5 watchdog expired actual=running expected=finished");
        summary();
        $finish;
    end

    initial begin
        int nbusy;
        repeat (3) @(negedge clk);
        chk("R1 reset restore_done", IMG_W'(restore_done), '0);
        chk("R1 reset image", cfg_image, '0);
        por_n = 1'b1; rst_n = 1'b1;
        @(negedge clk);
        chk("R1 restored", cfg_image, INIT_IMG);
        chk("R1 done flag", IMG_W'(restore_done), IMG_W'(1));
        chk("R2 reg3 field", IMG_W'(cfg_image[3*23 +: 23]), IMG_W'(word_of(INIT_IMG, 3)));

        host_write(5, 23'h5A5A5);
        chk("R8 idle write", IMG_W'(word_of(cfg_image, 5)), IMG_W'(23'h5A5A5));

        // save with mid-window strobes and write
        @(negedge clk); cmd_save = 1'b1;
        @(negedge clk); cmd_save = 1'b0;
        nbusy = 0;
        while (busy) begin
            nbusy++;
            if (nbusy == 3) begin
                host_we = 1'b1; host_addr = 3'd0; host_wdata = 23'h7FFFF; cmd_save_lock = 1'b1;
            end else begin
                host_we = 1'b0; cmd_save_lock = 1'b0;
            end
            @(negedge clk);
        end
        host_we = 1'b0; cmd_save_lock = 1'b0;
        chk("R5 busy length", IMG_W'(nbusy), IMG_W'(HOLD));
        chk("R6 strobe dropped lock", IMG_W'(locked), '0);
        chk("R6 strobe dropped err", IMG_W'(err_locked), '0);
        chk("R6 write masked", IMG_W'(word_of(cfg_image, 0)), IMG_W'(word_of(INIT_IMG, 0)));

        reset_pulse();
        chk("R3 saved reg5", IMG_W'(word_of(cfg_image, 5)), IMG_W'(23'h5A5A5));

        host_write(1, 23'h12345); save(0); wait_idle();
        host_write(1, 23'h00001); save(0); wait_idle();
        reset_pulse();
        chk("R3 repeated save", IMG_W'(word_of(cfg_image, 1)), IMG_W'(23'h00001));

        // both strobes plus a write in the same cycle
        @(negedge clk); cmd_save = 1'b1; cmd_save_lock = 1'b1;
        host_we = 1'b1; host_addr = 3'd6; host_wdata = 23'h7FFFF;
        @(negedge clk); cmd_save = 1'b0; cmd_save_lock = 1'b0; host_we = 1'b0;
        chk("R10 write with accepted save", IMG_W'(word_of(cfg_image, 6)), IMG_W'(word_of(INIT_IMG, 6)));
        chk("R9 accepted", IMG_W'(busy), IMG_W'(1));
        wait_idle();
        chk("R9 lock after dual strobe", IMG_W'(locked), IMG_W'(1));
        reset_pulse();
        chk("R4 lock survives reset", IMG_W'(locked), IMG_W'(1));

        // save attempts while locked
        @(negedge clk); cmd_save = 1'b1;
        host_we = 1'b1; host_addr = 3'd2; host_wdata = 23'h2AAAA;
        @(negedge clk); cmd_save = 1'b0; host_we = 1'b0;
        chk("R7 no busy when locked", IMG_W'(busy), '0);
        chk("R7 err set", IMG_W'(err_locked), IMG_W'(1));
        chk("R10 write with rejected save", IMG_W'(word_of(cfg_image, 2)), IMG_W'(23'h2AAAA));
        save(1);
        chk("R7 lock save ignored", IMG_W'(busy), '0);
        reset_pulse();
        chk("R7 store unchanged", IMG_W'(word_of(cfg_image, 2)), IMG_W'(word_of(INIT_IMG, 2)));
        chk("R7 err cleared by reset", IMG_W'(err_locked), '0);

        // power-on with a write during the restore cycle
        @(negedge clk); por_n = 1'b0; rst_n = 1'b0;
        @(negedge clk); por_n = 1'b1; rst_n = 1'b1;
        host_we = 1'b1; host_addr = 3'd4; host_wdata = 23'h00F0F;
        @(negedge clk); host_we = 1'b0;
        chk("R8 write during restore", IMG_W'(word_of(cfg_image, 4)), IMG_W'(word_of(INIT_IMG, 4)));
        chk("R4 power-on clears lock", IMG_W'(locked), '0);
        chk("R4 power-on image", cfg_image, INIT_IMG);
        repeat (2) @(negedge clk);

        summary();
        $finish;
    end

endmodule